// File: doc/BRIEF.md
# Banked memory address decoder

This block sits between an 8-bit CPU with a 16-bit address bus and the memories it drives. Every bus cycle is decoded into one of four chip selects: the flat low RAM, the I/O page, an 8K high-RAM bank window and a 16K ROM bank window. Two 8-bit bank registers live at fixed addresses in the I/O page. The CPU writes them and reads them back. Their stored values drive the upper address lines of the high RAM (8 lines, 21-bit physical address) and of the ROM (3 lines, 17-bit address).

The bank lines come straight from flops. They never depend on the current CPU address, so bank selection adds no delay to the memory access path. The memory sees the low CPU address bits as the offset inside a bank.

The installed high-RAM size is a parameter: 512K, 1024K, 1536K or 2048K. A bank number at or above the installed bank count is reduced modulo that count when it is written. The value that is stored, driven and read back is always a bank that exists.

Top module: `banked_addr_decode`

## Requirements
- R1: While `bus_valid` is 1, addresses 0x0000 to 0x9EFF assert only `sel_lowram`.
- R2: While `bus_valid` is 1, addresses 0x9F00 to 0x9FFF assert only `sel_io`.
- R3: While `bus_valid` is 1, addresses 0xA000 to 0xBFFF assert only `sel_hiram`.
- R4: While `bus_valid` is 1, addresses 0xC000 to 0xFFFF assert only `sel_rom`.
- R5: Exactly one chip select is high while `bus_valid` is 1, and none is high while it is 0.
- R6: A write cycle to 0x9F00 (valid, `cpu_we`=1) loads the high-RAM bank register on that clock edge. `hiram_bank` shows the new value from that edge on, and a read cycle at 0x9F00 returns it on `cpu_rdata`.
- R7: A write cycle to 0x9F01 stores bits [2:0] of the data in the ROM bank register, which drives `rom_bank`. A read at 0x9F01 returns the stored value in bits [2:0], and bits [7:3] always read as 0.
- R8: After reset, `hiram_bank` and `rom_bank` are 0 and both registers read back as 0.
- R9: A written high-RAM bank value v is stored as v mod (HRAM_KB/8). `hiram_bank` and readback both show the reduced value.
- R10: The bank registers keep their values unless a valid write cycle targets their own address. This covers `bus_valid`=0, `cpu_we`=0 and any other address. The bank outputs do not change while only `cpu_addr` changes.
- R11: `cpu_rdata` is 0 unless a valid read cycle (`cpu_we`=0) targets 0x9F00 or 0x9F01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_valid | input | 1 | Bus cycle in progress |
| cpu_rdata | output | 8 | Bank register readback data |
| sel_lowram | output | 1 | Low RAM chip select |
| sel_io | output | 1 | I/O page chip select |
| sel_hiram | output | 1 | High RAM window chip select |
| sel_rom | output | 1 | ROM window chip select |
| hiram_bank | output | 8 | High RAM upper address lines |
| rom_bank | output | 3 | ROM upper address lines |

## Verification
Some properties are checked by assertions on every cycle:
- one-hot chip selects gated by `bus_valid`;
- high-RAM bank value always below the installed count;
- both registers holding still without a matching write;
- the zero upper bits of ROM readback.

The bench sweeps every address, with the cycle both valid and idle, and checks the region boundaries against arithmetic expectations. It writes all 256 data values to each register to show the modulo reduction for a three-bank-quarter size, and the 3-bit ROM truncation. It also shows the reset values, and that misdirected or invalid writes leave both registers untouched.

// File: rtl/bankdec_pkg.sv
package bankdec_pkg;

  typedef struct packed {
    logic rom;
    logic hram;
    logic io;
    logic lram;
  } chip_sel_t;

  // Reduce a bank number below the installed count (count is a multiple of 64, at most 256)
  function automatic logic [7:0] bank_wrap(input logic [7:0] v, input logic [8:0] n);
    logic [8:0] r;
    r = {1'b0, v};
    for (int i = 0; i < 4; i++) begin
      if (r >= n) r = r - n;
    end
    return r[7:0];
  endfunction

endpackage

// File: rtl/bankdec_rstsync.sv
module bankdec_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/bankdec_map.sv
module bankdec_map
  import bankdec_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int IO_PAGE = 'h9F
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              valid,
  output chip_sel_t         sel
);
  localparam logic [7:0] IO_HI = 8'(IO_PAGE);

  always_comb begin
    sel = '0;
    if (valid) begin
      if (addr[ADDR_W-1 -: 2] == 2'b11)       sel.rom  = 1'b1;
      else if (addr[ADDR_W-1 -: 3] == 3'b101) sel.hram = 1'b1;
      else if (addr[ADDR_W-1 -: 8] == IO_HI)  sel.io   = 1'b1;
      else                                    sel.lram = 1'b1;
    end
  end

  // R5: one select per valid cycle, none when idle
  always_comb begin
    assert_one_select_R5: assert ($countones(sel) == (valid ? 1 : 0));
  end
endmodule

// File: rtl/bankdec_regs.sv
module bankdec_regs
  import bankdec_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ROM_W    = 3,
  parameter int HRAM_KB  = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hram,
  input  logic              wr_rom,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] hram_bank,
  output logic [ROM_W-1:0]  rom_bank
);
  localparam int         HRAM_BANKS = HRAM_KB / 8;
  localparam logic [8:0] BANKS_9    = 9'(HRAM_BANKS);

  logic [DATA_W-1:0] hram_q, hram_nxt;
  logic [ROM_W-1:0]  rom_q, rom_nxt;
  logic              hram_en, rom_en;

  always_comb begin
    hram_en  = wr_hram;
    rom_en   = wr_rom;
    hram_nxt = bank_wrap(wdata, BANKS_9);
    rom_nxt  = wdata[ROM_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hram_q <= '0;
    else if (hram_en) hram_q <= hram_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rom_q <= '0;
    else if (rom_en) rom_q <= rom_nxt;
  end

  assign hram_bank = hram_q;
  assign rom_bank  = rom_q;

  // R9: stored bank always exists
  always_comb begin
    assert_bank_in_range_R9: assert (!rst_n || (9'(hram_q) < BANKS_9));
  end

  // R10: registers hold without a matching write
  assert_hram_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hram |=> $stable(hram_bank));
  assert_rom_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_rom |=> $stable(rom_bank));
endmodule

// File: rtl/banked_addr_decode.sv
module banked_addr_decode
  import bankdec_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int ROM_W      = 3,
  parameter int HRAM_KB    = 2048,
  parameter int IO_PAGE    = 'h9F,
  parameter int HBANK_ADDR = 'h9F00,
  parameter int RBANK_ADDR = 'h9F01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  input  logic              bus_valid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              sel_lowram,
  output logic              sel_io,
  output logic              sel_hiram,
  output logic              sel_rom,
  output logic [DATA_W-1:0] hiram_bank,
  output logic [ROM_W-1:0]  rom_bank
);
  localparam logic [ADDR_W-1:0] HB_A = ADDR_W'(HBANK_ADDR);
  localparam logic [ADDR_W-1:0] RB_A = ADDR_W'(RBANK_ADDR);

  logic      rst_sync_n;
  chip_sel_t sel;
  logic      hit_hb, hit_rb, wr_hb, wr_rb, rd_hb, rd_rb;

  bankdec_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  bankdec_map #(.ADDR_W(ADDR_W), .IO_PAGE(IO_PAGE)) u_map (
    .addr(cpu_addr), .valid(bus_valid), .sel(sel)
  );

  always_comb begin
    hit_hb = bus_valid && (cpu_addr == HB_A);
    hit_rb = bus_valid && (cpu_addr == RB_A);
    wr_hb  = hit_hb && cpu_we;
    wr_rb  = hit_rb && cpu_we;
    rd_hb  = hit_hb && !cpu_we;
    rd_rb  = hit_rb && !cpu_we;
  end

  bankdec_regs #(.DATA_W(DATA_W), .ROM_W(ROM_W), .HRAM_KB(HRAM_KB)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_hram(wr_hb), .wr_rom(wr_rb),
    .wdata(cpu_wdata), .hram_bank(hiram_bank), .rom_bank(rom_bank)
  );

  always_comb begin
    cpu_rdata = '0;
    if (rd_hb)      cpu_rdata = hiram_bank;
    else if (rd_rb) cpu_rdata = {{(DATA_W-ROM_W){1'b0}}, rom_bank};
  end

  assign sel_lowram = sel.lram;
  assign sel_io     = sel.io;
  assign sel_hiram  = sel.hram;
  assign sel_rom    = sel.rom;

  // R7: reserved ROM bank bits read as zero
  assert_rom_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_rb |-> (cpu_rdata[DATA_W-1:ROM_W] == '0));
  // R6: bank register readback lies inside the I/O page select
  assert_reg_in_io_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_hb || rd_rb) |-> sel_io);
endmodule

// File: tb/banked_addr_decode_test.sv
module banked_addr_decode_test;
  localparam int KB    = 1536;
  localparam int BANKS = KB / 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_we, bus_valid;
  logic [7:0]  cpu_rdata, hiram_bank;
  logic        sel_lowram, sel_io, sel_hiram, sel_rom;
  logic [2:0]  rom_bank;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  banked_addr_decode #(.HRAM_KB(KB)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .bus_valid(bus_valid), .cpu_rdata(cpu_rdata),
    .sel_lowram(sel_lowram), .sel_io(sel_io), .sel_hiram(sel_hiram),
    .sel_rom(sel_rom), .hiram_bank(hiram_bank), .rom_bank(rom_bank)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic v);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1; bus_valid = v;
    @(negedge clk);
    cpu_we = 1'b0; bus_valid = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_we = 1'b0; bus_valid = 1'b1;
    #1 d = cpu_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  function automatic logic [3:0] exp_sel(input int a);
    if (a < 'h9F00) return 4'b0001;
    if (a < 'hA000) return 4'b0010;
    if (a < 'hC000) return 4'b0100;
    return 4'b1000;
  endfunction

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    string rq;
    rst_n = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_we = 1'b0; bus_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8 reset state
    chk("R8 hiram_bank", 32'(hiram_bank), 0);
    chk("R8 rom_bank", 32'(rom_bank), 0);
    rd(16'h9F00, d); chk("R8 hbank readback", 32'(d), 0);
    rd(16'h9F01, d); chk("R8 rbank readback", 32'(d), 0);

    // R6 / R9: all values into the high RAM bank register
    for (int v = 0; v < 256; v++) begin
      wr(16'h9F00, 8'(v), 1'b1);
      chk("R9 hiram_bank modulo", 32'(hiram_bank), 32'(v % BANKS));
      rd(16'h9F00, d);
      chk("R6 hbank readback", 32'(d), 32'(v % BANKS));
    end

    // R7: all values into the ROM bank register
    for (int v = 0; v < 256; v++) begin
      wr(16'h9F01, 8'(v), 1'b1);
      chk("R7 rom_bank", 32'(rom_bank), 32'(v & 7));
      rd(16'h9F01, d);
      chk("R7 rbank readback", 32'(d), 32'(v & 7));
    end

    // Preset values for hold checks
    wr(16'h9F00, 8'd77, 1'b1);
    wr(16'h9F01, 8'd5, 1'b1);

    // R10: writes that must not land
    wr(16'h9F00, 8'd12, 1'b0);
    wr(16'h9F01, 8'd2, 1'b0);
    chk("R10 idle write hbank", 32'(hiram_bank), 77);
    chk("R10 idle write rbank", 32'(rom_bank), 5);
    wr(16'h9F02, 8'd13, 1'b1);
    wr(16'h9EFF, 8'd3, 1'b1);
    wr(16'hA000, 8'd1, 1'b1);
    chk("R10 other addr hbank", 32'(hiram_bank), 77);
    chk("R10 other addr rbank", 32'(rom_bank), 5);
    rd(16'h9F00, d); chk("R10 hbank kept", 32'(d), 77);
    rd(16'h9F01, d); chk("R10 rbank kept", 32'(d), 5);

    // R11: readback zero elsewhere
    rd(16'h9F02, d); chk("R11 rdata other reg addr", 32'(d), 0);
    rd(16'hA000, d); chk("R11 rdata hiram addr", 32'(d), 0);
    @(negedge clk);
    cpu_addr = 16'h9F00; cpu_we = 1'b0; bus_valid = 1'b0;
    #1 chk("R11 rdata idle", 32'(cpu_rdata), 0);
    cpu_we = 1'b1; bus_valid = 1'b1;
    #1 chk("R11 rdata on write", 32'(cpu_rdata), 0);
    cpu_we = 1'b0; bus_valid = 1'b0;

    // R1-R5 address sweep; reads only, no writes occur
    @(negedge clk);
    for (int a = 0; a < 65536; a++) begin
      cpu_addr = 16'(a); bus_valid = 1'b1; cpu_we = 1'b0;
      #0.5;
      if (a < 'h9F00) rq = "R1";
      else if (a < 'hA000) rq = "R2";
      else if (a < 'hC000) rq = "R3";
      else rq = "R4";
      chk({rq, " select"}, 32'({sel_rom, sel_hiram, sel_io, sel_lowram}), 32'(exp_sel(a)));
      bus_valid = 1'b0;
      #0.5;
      chk("R5 idle no select", 32'({sel_rom, sel_hiram, sel_io, sel_lowram}), 0);
    end
    chk("R10 hbank unchanged by addr sweep", 32'(hiram_bank), 77);
    chk("R10 rbank unchanged by addr sweep", 32'(rom_bank), 5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule